// File: doc/BRIEF.md
# Host Bus Cycle Tracker

This block watches a 32-bit host processor bus from the chip-set side and classifies every bus cycle. It does not drive the bus. All inputs are active-low where the bus defines them that way, and all are sampled on the rising edge of the bus clock. When the address strobe is low, the block captures the three cycle-definition lines and the byte enables. It also decodes the subtype of special cycles and detects the start of line write-backs and snoop write-backs.

After the capture, the tracker follows the cycle until it completes. A single ready ends a non-burst cycle. In a burst, each burst ready is one transfer, and the burst ends on the burst ready that comes with burst last. The cacheability pin is low for a cacheable line and high for an uncached page. It is sampled from the address strobe until the first ready of either kind, and a high value anywhere in that window makes a fill uncached. Protocol faults are reported as one-cycle pulses: a burst that runs past four transfers, and an address strobe that arrives during an active cycle.

All outputs are registered. Pulses last one clock, in the clock after the edge that caused them. The captured fields hold their values until the next accepted address strobe.

Top module: `hbus_cycle_tracker`

## Requirements
- R1: When `ads_n` is low while no cycle is active, the next clock shows `cyc_active`=1 and `cyc_code`={`cyc_mem`,`cyc_data`,`cyc_write`}, coded 000 interrupt acknowledge, 001 special, 010 IO read, 011 IO write, 100 code read, 110 memory read, 111 memory write. In the same clock `byte_en`=~`be_n`. Definition lines at any other clock have no effect on these outputs.
- R2: `ready_n` low during an active cycle gives, in the next clock, one-clock pulses on `xfer_stb` and `cyc_done`, with `cyc_active`=0. Ready of either kind while idle has no effect.
- R3: `burst_ready_n` low during an active cycle pulses `xfer_stb` and sets `burst_mode`. The cycle stays active until a burst ready that comes with `burst_last_n` low, which also pulses `cyc_done`.
- R4: If the fourth burst ready of a cycle comes without burst last, the cycle ends. `cyc_done` and `burst_err` pulse together.
- R5: `fill_cacheable`=1 only for a memory or code read (`cyc_mem`=1, `cyc_write`=0) where `cache_n` was low at the address strobe and on every active clock up to and including the first ready or burst ready. Samples after that are ignored.
- R6: An address strobe with `cyc_write`=1, `cache_n` low and `hitm_n` high gives `line_wb`=1 and `snoop_wb`=0.
- R7: An address strobe with `cyc_write`=1, `cache_n` low and `hitm_n` low gives `snoop_wb`=1 and `line_wb`=0. Without `cache_n` low, neither flag is set.
- R8: `spec_kind` depends on `be_n` and `addr_sel` (address bits 4..2) at the strobe.
  - For code 001 it is 1 for 1110/000, 2 for 1101/000, 3 for 1011/000, 4 for 0111/000, 5 for 1110/100 and 6 for 1110/010.
  - Any other combination with code 001 gives 7.
  - For every other code it is 0.
- R9: An address strobe during an active cycle pulses `overlap_err` in the next clock. It leaves the captured outputs unchanged and does not restart the cycle.
- R10: While `rst_n` is low, every output is 0.
- R11: `ready_n` and `burst_ready_n` low together end the cycle as a single transfer, and `burst_mode` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ads_n | input | 1 | Address strobe, active low |
| cyc_mem | input | 1 | 1 = memory, 0 = IO |
| cyc_data | input | 1 | 1 = data, 0 = control |
| cyc_write | input | 1 | 1 = write, 0 = read |
| be_n | input | 4 | Byte enables, active low |
| addr_sel | input | 3 | Address bits 4..2 |
| ready_n | input | 1 | Single-transfer ready, active low |
| burst_ready_n | input | 1 | Burst transfer ready, active low |
| burst_last_n | input | 1 | Final burst transfer, active low |
| cache_n | input | 1 | Cacheability pin, low = cacheable |
| hitm_n | input | 1 | Snoop hit on modified line, active low |
| cyc_active | output | 1 | A cycle is in progress |
| cyc_code | output | 3 | Captured cycle code |
| byte_en | output | 4 | Captured byte enables, active high |
| spec_kind | output | 3 | Special-cycle subtype |
| burst_mode | output | 1 | Current or last cycle used burst ready |
| xfer_stb | output | 1 | One pulse per completed transfer |
| cyc_done | output | 1 | Cycle completed |
| burst_err | output | 1 | Burst ran past four transfers |
| overlap_err | output | 1 | Strobe arrived during an active cycle |
| fill_cacheable | output | 1 | Read cycle qualified as cacheable |
| line_wb | output | 1 | Cycle is a line write-back |
| snoop_wb | output | 1 | Cycle is a snoop write-back |

## Verification
Completion and the overlap error can fall in the same clock. This happens when a new address strobe arrives on the edge where the ready of the current cycle is sampled. The bench drives the strobe and ready low together and expects both pulses in the following clock. It also expects `cyc_active` low and the old cycle's code and write-back flags still showing, with no restart. Separately, the bench drives a strobe in the middle of a cycle and expects the error alone, with the cycle still active and ending later on its own ready.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    localparam int BE_W  = 4;
    localparam int SEL_W = 3;
    localparam int DEF_W = 3;

    localparam logic [DEF_W-1:0] CODE_SPECIAL = 3'b001;

    typedef enum logic [2:0] {
        SP_NONE      = 3'd0,
        SP_SHUTDOWN  = 3'd1,
        SP_FLUSH     = 3'd2,
        SP_HALT      = 3'd3,
        SP_WBACK     = 3'd4,
        SP_FLUSH_ACK = 3'd5,
        SP_TRACE     = 3'd6,
        SP_OTHER     = 3'd7
    } spec_e;

    typedef struct packed {
        logic             active;
        logic             first_pend;
        logic [DEF_W-1:0] code;
        logic [BE_W-1:0]  be;
        spec_e            spec;
        logic             fill;
        logic             lwb;
        logic             swb;
        logic             burst;
        logic             stb;
        logic             done;
        logic             perr;
        logic             oerr;
    } trk_state_t;

endpackage

// File: rtl/hbc_spec_decode.sv
module hbc_spec_decode
    import hbc_pkg::*;
(
    input  logic [DEF_W-1:0] code,
    input  logic [BE_W-1:0]  be_n,
    input  logic [SEL_W-1:0] addr_sel,
    output spec_e            kind
);
    // The subtype is looked up only for special cycles.
    always_comb begin
        kind = SP_NONE;
        if (code == CODE_SPECIAL) begin
            kind = SP_OTHER;
            unique case ({be_n, addr_sel})
                {4'b1110, 3'b000}: kind = SP_SHUTDOWN;
                {4'b1101, 3'b000}: kind = SP_FLUSH;
                {4'b1011, 3'b000}: kind = SP_HALT;
                {4'b0111, 3'b000}: kind = SP_WBACK;
                {4'b1110, 3'b100}: kind = SP_FLUSH_ACK;
                {4'b1110, 3'b010}: kind = SP_TRACE;
                default:           kind = SP_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/hbc_start_detect.sv
module hbc_start_detect (
    input  logic ads_n,
    input  logic cyc_mem,
    input  logic cyc_write,
    input  logic cache_n,
    input  logic hitm_n,
    output logic fill_start,
    output logic line_wb_start,
    output logic snoop_wb_start
);
    logic wr_cache;

    always_comb begin
        wr_cache       = !ads_n && cyc_write && !cache_n;
        line_wb_start  = wr_cache && hitm_n;
        snoop_wb_start = wr_cache && !hitm_n;
        fill_start     = !ads_n && cyc_mem && !cyc_write && !cache_n;
    end
endmodule

// File: rtl/hbc_beat_ctr.sv
module hbc_beat_ctr #(
    parameter int BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int CW = (BEATS > 1) ? $clog2(BEATS) + 1 : 1;
    localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != LAST)) begin
            cnt_d = cnt_q + CW'(1);
        end
        at_last = (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/hbus_cycle_tracker.sv
module hbus_cycle_tracker
    import hbc_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ads_n,
    input  logic       cyc_mem,
    input  logic       cyc_data,
    input  logic       cyc_write,
    input  logic [3:0] be_n,
    input  logic [2:0] addr_sel,
    input  logic       ready_n,
    input  logic       burst_ready_n,
    input  logic       burst_last_n,
    input  logic       cache_n,
    input  logic       hitm_n,
    output logic       cyc_active,
    output logic [2:0] cyc_code,
    output logic [3:0] byte_en,
    output logic [2:0] spec_kind,
    output logic       burst_mode,
    output logic       xfer_stb,
    output logic       cyc_done,
    output logic       burst_err,
    output logic       overlap_err,
    output logic       fill_cacheable,
    output logic       line_wb,
    output logic       snoop_wb
);
    trk_state_t s_d, s_q;

    logic [DEF_W-1:0] def_now;
    spec_e            spec_now;
    logic             fill_start, lwb_start, swb_start;
    logic             beat_clr, beat_inc, beat_last;

    assign def_now = {cyc_mem, cyc_data, cyc_write};

    hbc_spec_decode u_spec (
        .code     (def_now),
        .be_n     (be_n),
        .addr_sel (addr_sel),
        .kind     (spec_now)
    );

    hbc_start_detect u_start (
        .ads_n          (ads_n),
        .cyc_mem        (cyc_mem),
        .cyc_write      (cyc_write),
        .cache_n        (cache_n),
        .hitm_n         (hitm_n),
        .fill_start     (fill_start),
        .line_wb_start  (lwb_start),
        .snoop_wb_start (swb_start)
    );

    hbc_beat_ctr #(.BEATS(BEATS)) u_beats (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (beat_clr),
        .inc     (beat_inc),
        .at_last (beat_last)
    );

    always_comb begin
        s_d      = s_q;
        s_d.stb  = 1'b0;
        s_d.done = 1'b0;
        s_d.perr = 1'b0;
        s_d.oerr = 1'b0;
        beat_clr = 1'b0;
        beat_inc = 1'b0;

        if (!s_q.active) begin
            // Idle: only a strobe matters; stray readies are dropped.
            if (!ads_n) begin
                s_d.active     = 1'b1;
                s_d.first_pend = 1'b1;
                s_d.code       = def_now;
                s_d.be         = ~be_n;
                s_d.spec       = spec_now;
                s_d.fill       = fill_start;
                s_d.lwb        = lwb_start;
                s_d.swb        = swb_start;
                s_d.burst      = 1'b0;
                beat_clr       = 1'b1;
            end
        end else begin
            if (!ads_n) begin
                s_d.oerr = 1'b1;
            end
            // Cacheability window closes with the first ready of either kind.
            if (s_q.first_pend) begin
                s_d.fill = s_q.fill && !cache_n;
            end
            if (!ready_n) begin
                s_d.stb        = 1'b1;
                s_d.done       = 1'b1;
                s_d.active     = 1'b0;
                s_d.first_pend = 1'b0;
            end else if (!burst_ready_n) begin
                s_d.stb        = 1'b1;
                s_d.burst      = 1'b1;
                s_d.first_pend = 1'b0;
                beat_inc       = 1'b1;
                if (!burst_last_n) begin
                    s_d.done   = 1'b1;
                    s_d.active = 1'b0;
                end else if (beat_last) begin
                    s_d.done   = 1'b1;
                    s_d.perr   = 1'b1;
                    s_d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cyc_active     = s_q.active;
    assign cyc_code       = s_q.code;
    assign byte_en        = s_q.be;
    assign spec_kind      = s_q.spec;
    assign burst_mode     = s_q.burst;
    assign xfer_stb       = s_q.stb;
    assign cyc_done       = s_q.done;
    assign burst_err      = s_q.perr;
    assign overlap_err    = s_q.oerr;
    assign fill_cacheable = s_q.fill;
    assign line_wb        = s_q.lwb;
    assign snoop_wb       = s_q.swb;
endmodule

// File: rtl/hbc_checker.sv
module hbc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ads_n,
    input logic       cyc_active,
    input logic [2:0] cyc_code,
    input logic [2:0] spec_kind,
    input logic       burst_mode,
    input logic       xfer_stb,
    input logic       cyc_done,
    input logic       burst_err,
    input logic       overlap_err,
    input logic       fill_cacheable,
    input logic       line_wb,
    input logic       snoop_wb
);
    p_start_on_ads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_active) |-> $past(!ads_n));

    p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> (!cyc_active && xfer_stb));

    p_err_in_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        burst_err |-> (cyc_done && burst_mode));

    p_fill_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cacheable |-> (cyc_code[2] && !cyc_code[0]));

    p_wb_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_wb |-> cyc_code[0]);

    p_wb_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_wb && snoop_wb));

    p_spec_only_special_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_kind != 3'd0) |-> (cyc_code == 3'b001));

    p_overlap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |-> $stable(cyc_code));
endmodule

bind hbus_cycle_tracker hbc_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ads_n          (ads_n),
    .cyc_active     (cyc_active),
    .cyc_code       (cyc_code),
    .spec_kind      (spec_kind),
    .burst_mode     (burst_mode),
    .xfer_stb       (xfer_stb),
    .cyc_done       (cyc_done),
    .burst_err      (burst_err),
    .overlap_err    (overlap_err),
    .fill_cacheable (fill_cacheable),
    .line_wb        (line_wb),
    .snoop_wb       (snoop_wb)
);

// File: tb/hbus_cycle_tracker_tb_top.sv
`timescale 1ns/1ps
module hbus_cycle_tracker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ads_n = 1'b1;
    logic       cyc_mem = 1'b0, cyc_data = 1'b0, cyc_write = 1'b0;
    logic [3:0] be_n = 4'hF;
    logic [2:0] addr_sel = 3'b000;
    logic       ready_n = 1'b1, burst_ready_n = 1'b1, burst_last_n = 1'b1;
    logic       cache_n = 1'b1, hitm_n = 1'b1;
    logic       cyc_active, burst_mode, xfer_stb, cyc_done, burst_err, overlap_err;
    logic       fill_cacheable, line_wb, snoop_wb;
    logic [2:0] cyc_code, spec_kind;
    logic [3:0] byte_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hbus_cycle_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .cyc_mem(cyc_mem),
        .cyc_data(cyc_data), .cyc_write(cyc_write), .be_n(be_n),
        .addr_sel(addr_sel), .ready_n(ready_n), .burst_ready_n(burst_ready_n),
        .burst_last_n(burst_last_n), .cache_n(cache_n), .hitm_n(hitm_n),
        .cyc_active(cyc_active), .cyc_code(cyc_code), .byte_en(byte_en),
        .spec_kind(spec_kind), .burst_mode(burst_mode), .xfer_stb(xfer_stb),
        .cyc_done(cyc_done), .burst_err(burst_err), .overlap_err(overlap_err),
        .fill_cacheable(fill_cacheable), .line_wb(line_wb), .snoop_wb(snoop_wb)
    );

    // in  [34:19]: ads_n, code[3], be_n[4], sel[3], rdy_n, brdy_n, blast_n, cache_n, hitm_n
    // exp [18:0] : active, code[3], be[4], stb, done, burst, fill, lwb, swb, spec[3], perr, oerr
    localparam int NV = 37;
    localparam logic [34:0] VEC [NV] = '{
        {16'b1_000_1111_000_11111, 19'b0_000_0000_0_0_0_0_0_0_000_0_0},
        {16'b0_110_0000_000_11101, 19'b1_110_1111_0_0_0_1_0_0_000_0_0},
        {16'b1_011_1010_000_11101, 19'b1_110_1111_0_0_0_1_0_0_000_0_0},
        {16'b1_000_1111_000_01101, 19'b0_110_1111_1_1_0_1_0_0_000_0_0},
        {16'b1_000_1111_000_11111, 19'b0_110_1111_0_0_0_1_0_0_000_0_0},
        {16'b0_110_0000_000_11101, 19'b1_110_1111_0_0_0_1_0_0_000_0_0},
        {16'b1_000_1111_000_10101, 19'b1_110_1111_1_0_1_1_0_0_000_0_0},
        {16'b1_000_1111_000_10111, 19'b1_110_1111_1_0_1_1_0_0_000_0_0},
        {16'b1_000_1111_000_11111, 19'b1_110_1111_0_0_1_1_0_0_000_0_0},
        {16'b1_000_1111_000_10111, 19'b1_110_1111_1_0_1_1_0_0_000_0_0},
        {16'b1_000_1111_000_10011, 19'b0_110_1111_1_1_1_1_0_0_000_0_0},
        {16'b0_110_1100_000_11101, 19'b1_110_0011_0_0_0_1_0_0_000_0_0},
        {16'b1_000_1111_000_11111, 19'b1_110_0011_0_0_0_0_0_0_000_0_0},
        {16'b1_000_1111_000_01101, 19'b0_110_0011_1_1_0_0_0_0_000_0_0},
        {16'b0_111_0000_000_11101, 19'b1_111_1111_0_0_0_0_1_0_000_0_0},
        {16'b1_000_1111_000_10111, 19'b1_111_1111_1_0_1_0_1_0_000_0_0},
        {16'b1_000_1111_000_10111, 19'b1_111_1111_1_0_1_0_1_0_000_0_0},
        {16'b1_000_1111_000_10111, 19'b1_111_1111_1_0_1_0_1_0_000_0_0},
        {16'b1_000_1111_000_10111, 19'b0_111_1111_1_1_1_0_1_0_000_1_0},
        {16'b0_111_0000_000_11100, 19'b1_111_1111_0_0_0_0_0_1_000_0_0},
        {16'b0_011_1110_000_01111, 19'b0_111_1111_1_1_0_0_0_1_000_0_1},
        {16'b1_000_1111_000_11111, 19'b0_111_1111_0_0_0_0_0_1_000_0_0},
        {16'b0_001_1011_000_11111, 19'b1_001_0100_0_0_0_0_0_0_011_0_0},
        {16'b1_001_1011_000_01111, 19'b0_001_0100_1_1_0_0_0_0_011_0_0},
        {16'b0_001_1110_100_11111, 19'b1_001_0001_0_0_0_0_0_0_101_0_0},
        {16'b0_010_0000_000_11111, 19'b1_001_0001_0_0_0_0_0_0_101_0_1},
        {16'b1_000_1111_000_00111, 19'b0_001_0001_1_1_0_0_0_0_101_0_0},
        {16'b1_000_1111_000_01111, 19'b0_001_0001_0_0_0_0_0_0_101_0_0},
        {16'b1_000_1111_000_10011, 19'b0_001_0001_0_0_0_0_0_0_101_0_0},
        {16'b0_011_0000_000_11111, 19'b1_011_1111_0_0_0_0_0_0_000_0_0},
        {16'b1_000_1111_000_01111, 19'b0_011_1111_1_1_0_0_0_0_000_0_0},
        {16'b0_001_0000_000_11111, 19'b1_001_1111_0_0_0_0_0_0_111_0_0},
        {16'b1_000_1111_000_01111, 19'b0_001_1111_1_1_0_0_0_0_111_0_0},
        {16'b0_111_0000_000_11110, 19'b1_111_1111_0_0_0_0_0_0_000_0_0},
        {16'b1_000_1111_000_01111, 19'b0_111_1111_1_1_0_0_0_0_000_0_0},
        {16'b0_100_0000_000_11101, 19'b1_100_1111_0_0_0_1_0_0_000_0_0},
        {16'b1_000_1111_000_01101, 19'b0_100_1111_1_1_0_1_0_0_000_0_0}
    };

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic [15:0] v);
        {ads_n, cyc_mem, cyc_data, cyc_write, be_n, addr_sel,
         ready_n, burst_ready_n, burst_last_n, cache_n, hitm_n} = v;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_zero(input string tag);
        chk(tag, "active", int'(cyc_active), 0);
        chk(tag, "code", int'(cyc_code), 0);
        chk(tag, "be", int'(byte_en), 0);
        chk(tag, "outs", int'({xfer_stb, cyc_done, burst_mode, burst_err, overlap_err,
                               fill_cacheable, line_wb, snoop_wb, spec_kind}), 0);
    endtask

    localparam logic [15:0] IDLE = 16'b1_000_1111_000_11111;

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R10 got=hang exp=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        drive(IDLE);
        repeat (3) @(posedge clk);
        #1;
        check_zero("R10");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [18:0] e;
            drive(VEC[i][34:19]);
            e = VEC[i][18:0];
            step();
            chk("R1", $sformatf("v%0d active", i), int'(cyc_active), int'(e[18]));
            chk("R1", $sformatf("v%0d code", i), int'(cyc_code), int'(e[17:15]));
            chk("R1", $sformatf("v%0d byte_en", i), int'(byte_en), int'(e[14:11]));
            chk("R2", $sformatf("v%0d xfer_stb", i), int'(xfer_stb), int'(e[10]));
            chk("R2", $sformatf("v%0d cyc_done", i), int'(cyc_done), int'(e[9]));
            chk("R3", $sformatf("v%0d burst_mode", i), int'(burst_mode), int'(e[8]));
            chk("R5", $sformatf("v%0d fill", i), int'(fill_cacheable), int'(e[7]));
            chk("R6", $sformatf("v%0d line_wb", i), int'(line_wb), int'(e[6]));
            chk("R7", $sformatf("v%0d snoop_wb", i), int'(snoop_wb), int'(e[5]));
            chk("R8", $sformatf("v%0d spec", i), int'(spec_kind), int'(e[4:2]));
            chk("R4", $sformatf("v%0d burst_err", i), int'(burst_err), int'(e[1]));
            chk("R9", $sformatf("v%0d overlap", i), int'(overlap_err), int'(e[0]));
        end

        // R11: ready and burst ready together on a read ends as a single transfer.
        drive(16'b0_110_0000_000_11111); step();
        drive(16'b1_000_1111_000_00011); step();
        chk("R11", "done", int'(cyc_done), 1);
        chk("R11", "burst_mode", int'(burst_mode), 0);
        chk("R11", "active", int'(cyc_active), 0);

        // R3: a one-beat burst ended by burst last on the first transfer.
        drive(16'b0_110_0000_000_11111); step();
        drive(16'b1_000_1111_000_10011); step();
        chk("R3", "short burst done", int'(cyc_done), 1);
        chk("R3", "short burst mode", int'(burst_mode), 1);
        chk("R4", "short burst no err", int'(burst_err), 0);

        // R10: reset in the middle of a write-back clears everything.
        drive(16'b0_111_0000_000_11101); step();
        chk("R6", "pre-reset wb", int'(line_wb), 1);
        drive(IDLE);
        #1 rst_n = 1'b0;
        #1;
        check_zero("R10");
        step();
        check_zero("R10");
        rst_n = 1'b1;

        // R2: ready after reset with no cycle active is ignored.
        drive(16'b1_000_1111_000_01111); step();
        chk("R2", "idle ready stb", int'(xfer_stb), 0);
        chk("R2", "idle ready done", int'(cyc_done), 0);
        drive(IDLE); step();

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule